// File: doc/BRIEF.md
# Asynchronous Memory Bus Cycle Sampler

This block sits behind the pins of a parallel, byte-wide memory bus driven by an external host that knows nothing about the local clock. It samples the three active-low strobes (chip select, write strobe, read strobe) together with the address and data buses, and turns them into clean synchronous events. Each accepted write cycle becomes a single-clock write pulse that carries the address and data of that cycle. Each new read becomes a single-clock read-start pulse. The block also produces the enable for the data-bus output driver.

All asynchronous inputs first pass through a multi-flop synchronizer. The address and data are delayed by the same number of clocks as the filtered strobes, so they stay aligned with them. The write cycle is the window in which both chip select and write strobe are low. The address is taken when the later of the two falls. The data is taken when the earlier of the two rises, and that rise also ends the cycle. Pulses on chip select or write strobe that are shorter than a parameterised number of clocks are filtered out. A write during which the read strobe is seen low is discarded.

Top module: `bus_cycle_sampler`

## Requirements
- R1: While `rst_n` is low, `dq_oe`, `wr_strobe` and `rd_start` are 0, and `wr_addr` and `wr_data` read 0.
- R2: Each accepted write cycle produces exactly one `wr_strobe` pulse, one clock wide, after the first of `ce_n`/`we_n` rises.
- R3: `wr_addr` holds the address present when the later of `ce_n` and `we_n` fell. It changes only in a clock where `wr_strobe` is 1.
- R4: `wr_data` holds the data present when the earlier of `ce_n` and `we_n` rose, not the data present at the later rise.
- R5: If `oe_n` is seen low at any point in a write cycle, including its start and end, the cycle produces no `wr_strobe`.
- R6: `rd_start` pulses for one clock each time the filtered `ce_n` falls.
- R7: While `ce_n` stays low, each change of `addr_in` produces one `rd_start` pulse. A change of `addr_in` while `ce_n` is high produces none.
- R8: A level on `ce_n` or `we_n` lasting fewer than `GLITCH_CYC` clocks is ignored, whether it is a low pulse or a high pulse. A level lasting `GLITCH_CYC` clocks or more is accepted.
- R9: `dq_oe` is 1 only while both `ce_n` and `oe_n` are low. It is 0 when either of them is high.
- R10: A reset applied during a write cycle cancels that cycle. No strobe follows when its strobes later rise, and the next complete cycle is accepted normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Synchronous reset, active low |
| ce_n | input | 1 | Asynchronous chip select, active low |
| we_n | input | 1 | Asynchronous write strobe, active low |
| oe_n | input | 1 | Asynchronous read strobe, active low |
| addr_in | input | ADDR_W | Asynchronous address bus |
| data_in | input | DATA_W | Asynchronous write data bus |
| wr_strobe | output | 1 | One-clock pulse per accepted write |
| wr_addr | output | ADDR_W | Address of the last accepted write |
| wr_data | output | DATA_W | Data of the last accepted write |
| rd_start | output | 1 | One-clock pulse per new read |
| dq_oe | output | 1 | Enable for the data-bus output driver |

## Verification
The hardest case to reach is one where the two edges that define a cycle come from different strobes and the buses change between them. The value taken at the wrong edge then differs from the value taken at the right one. The stimulus moves the address between the two falling edges and the data between the two rising edges, with margins longer than the filter latency. It sweeps all four orderings of which strobe falls first and which rises first. Filter acceptance is reached by sweeping the pulse width across the threshold on both strobes, with both low-going and high-going pulses.

// File: rtl/bcs_pkg.sv
package bcs_pkg;
   // Index of each control pin inside the synchronized control vector
   localparam int PIN_CE   = 0;
   localparam int PIN_WE   = 1;
   localparam int PIN_OE   = 2;
   localparam int NUM_CTRL = 3;
endpackage

// File: rtl/bcs_pipe.sv
// Plain register chain used both as synchronizer and as alignment delay.
module bcs_pipe #(
   parameter int W     = 1,
   parameter int DEPTH = 2
) (
   input  logic         clk,
   input  logic [W-1:0] din,
   output logic [W-1:0] dout
);
   logic [W-1:0] stg [DEPTH];

   always_ff @(posedge clk) stg[0] <= din;

   generate
      for (genvar i = 1; i < DEPTH; i++) begin : g_stage
         always_ff @(posedge clk) stg[i] <= stg[i-1];
      end
   endgenerate

   assign dout = stg[DEPTH-1];
endmodule

// File: rtl/bcs_deglitch.sv
// A new level is passed on only after it has been seen for HOLD samples in a row.
module bcs_deglitch #(
   parameter int HOLD = 3
) (
   input  logic clk,
   input  logic rst_n,
   input  logic din,
   output logic dout
);
   generate
      if (HOLD <= 1) begin : g_direct
         always_ff @(posedge clk) dout <= din;
      end else begin : g_count
         localparam int CW = $clog2(HOLD + 1);
         logic [CW-1:0] cnt;
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               dout <= din;            // track the pin so release makes no false edge
               cnt  <= '0;
            end else if (din == dout) begin
               cnt  <= '0;
            end else if (cnt == CW'(HOLD - 1)) begin
               dout <= din;
               cnt  <= '0;
            end else begin
               cnt  <= cnt + 1'b1;
            end
         end
      end
   endgenerate
endmodule

// File: rtl/bcs_write_capture.sv
// Frames write cycles: address at the opening edge, data at the closing edge.
module bcs_write_capture #(
   parameter int ADDR_W = 20,
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              act,
   input  logic              oe_hi,
   input  logic [ADDR_W-1:0] addr_in,
   input  logic [DATA_W-1:0] data_in,
   output logic              wr_strobe,
   output logic [ADDR_W-1:0] wr_addr,
   output logic [DATA_W-1:0] wr_data
);
   logic              act_q;
   logic              in_cyc;
   logic              oe_good;
   logic [ADDR_W-1:0] addr_hold;
   logic              open_evt;
   logic              close_evt;

   assign open_evt  = act && !act_q;
   assign close_evt = !act && act_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         act_q     <= act;     // a cycle already open at release never opens
         in_cyc    <= 1'b0;
         oe_good   <= 1'b0;
         addr_hold <= '0;
         wr_strobe <= 1'b0;
         wr_addr   <= '0;
         wr_data   <= '0;
      end else begin
         act_q     <= act;
         wr_strobe <= 1'b0;
         if (open_evt) begin
            in_cyc    <= 1'b1;
            addr_hold <= addr_in;
            oe_good   <= oe_hi;
         end else if (in_cyc && act) begin
            oe_good   <= oe_good && oe_hi;
         end
         if (close_evt && in_cyc) begin
            in_cyc <= 1'b0;
            if (oe_good && oe_hi) begin
               wr_strobe <= 1'b1;
               wr_addr   <= addr_hold;
               wr_data   <= data_in;
            end
         end
      end
   end
endmodule

// File: rtl/bcs_read_detect.sv
// Flags a new read on select assertion or on an address move under select.
module bcs_read_detect #(
   parameter int ADDR_W = 20
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sel,
   input  logic [ADDR_W-1:0] addr,
   output logic              rd_start
);
   logic              sel_q;
   logic [ADDR_W-1:0] addr_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sel_q    <= sel;
         addr_q   <= addr;
         rd_start <= 1'b0;
      end else begin
         sel_q    <= sel;
         addr_q   <= addr;
         rd_start <= (sel && !sel_q) || (sel && sel_q && (addr != addr_q));
      end
   end
endmodule

// File: rtl/bus_cycle_sampler.sv
module bus_cycle_sampler
   import bcs_pkg::*;
#(
   parameter int ADDR_W      = 20,
   parameter int DATA_W      = 8,
   parameter int SYNC_STAGES = 2,
   parameter int GLITCH_CYC  = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ce_n,
   input  logic              we_n,
   input  logic              oe_n,
   input  logic [ADDR_W-1:0] addr_in,
   input  logic [DATA_W-1:0] data_in,
   output logic              wr_strobe,
   output logic [ADDR_W-1:0] wr_addr,
   output logic [DATA_W-1:0] wr_data,
   output logic              rd_start,
   output logic              dq_oe
);
   // Bus values are delayed to match the filtered strobes
   localparam int DLY   = SYNC_STAGES + GLITCH_CYC;
   localparam int BUS_W = ADDR_W + DATA_W;

   generate
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("SYNC_STAGES must be at least 2");
      end
      if (GLITCH_CYC < 1) begin : g_bad_glitch
         $error("GLITCH_CYC must be at least 1");
      end
      if (ADDR_W < 1 || DATA_W < 1) begin : g_bad_width
         $error("bus widths must be positive");
      end
   endgenerate

   logic [NUM_CTRL-1:0] ctrl_raw;
   logic [NUM_CTRL-1:0] ctrl_sync;
   logic                ce_sync;
   logic                we_sync;
   logic                oe_sync;
   logic                ce_filt;
   logic                we_filt;
   logic                wr_act;
   logic [BUS_W-1:0]    bus_dly;
   logic [ADDR_W-1:0]   addr_dly;
   logic [DATA_W-1:0]   data_dly;
   logic                oe_drv;

   always_comb begin
      ctrl_raw         = '1;
      ctrl_raw[PIN_CE] = ce_n;
      ctrl_raw[PIN_WE] = we_n;
      ctrl_raw[PIN_OE] = oe_n;
   end

   bcs_pipe #(.W(NUM_CTRL), .DEPTH(SYNC_STAGES)) u_ctrl_sync (
      .clk  (clk),
      .din  (ctrl_raw),
      .dout (ctrl_sync)
   );

   assign ce_sync = ctrl_sync[PIN_CE];
   assign we_sync = ctrl_sync[PIN_WE];
   assign oe_sync = ctrl_sync[PIN_OE];

   bcs_pipe #(.W(BUS_W), .DEPTH(DLY)) u_bus_dly (
      .clk  (clk),
      .din  ({addr_in, data_in}),
      .dout (bus_dly)
   );

   assign addr_dly = bus_dly[BUS_W-1:DATA_W];
   assign data_dly = bus_dly[DATA_W-1:0];

   bcs_deglitch #(.HOLD(GLITCH_CYC)) u_ce_filt (
      .clk  (clk),
      .rst_n(rst_n),
      .din  (ce_sync),
      .dout (ce_filt)
   );

   bcs_deglitch #(.HOLD(GLITCH_CYC)) u_we_filt (
      .clk  (clk),
      .rst_n(rst_n),
      .din  (we_sync),
      .dout (we_filt)
   );

   assign wr_act = !ce_filt && !we_filt;

   bcs_write_capture #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_wr (
      .clk      (clk),
      .rst_n    (rst_n),
      .act      (wr_act),
      .oe_hi    (oe_sync),
      .addr_in  (addr_dly),
      .data_in  (data_dly),
      .wr_strobe(wr_strobe),
      .wr_addr  (wr_addr),
      .wr_data  (wr_data)
   );

   bcs_read_detect #(.ADDR_W(ADDR_W)) u_rd (
      .clk     (clk),
      .rst_n   (rst_n),
      .sel     (!ce_filt),
      .addr    (addr_dly),
      .rd_start(rd_start)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) oe_drv <= 1'b0;
      else        oe_drv <= !ce_filt && !oe_sync;
   end

   // Reset blanks the driver at once, without waiting for a clock
   assign dq_oe = rst_n && oe_drv;
endmodule

// File: rtl/bcs_checker.sv
module bcs_checker #(
   parameter int ADDR_W = 20
) (
   input logic              clk,
   input logic              rst_n,
   input logic              dq_oe,
   input logic              wr_strobe,
   input logic [ADDR_W-1:0] wr_addr,
   input logic              ce_filt,
   input logic              ce_sync,
   input logic              wr_act
);
   // R1: driver is off whenever reset is applied
   p_quiet_in_reset_r1: assert property (@(posedge clk) !rst_n |-> !dq_oe);

   // R2: strobe never lasts more than one clock
   p_strobe_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
      wr_strobe |=> !wr_strobe);

   // R2: strobe follows the close of a cycle that was open the clock before
   p_strobe_at_close_r2: assert property (@(posedge clk) disable iff (!rst_n)
      wr_strobe |-> (!$past(wr_act) && $past(wr_act, 2)));

   // R3: captured address is only updated together with the strobe
   p_addr_with_strobe_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(wr_addr) |-> wr_strobe);

   // R8: the filtered select only moves to a level already on the synchronizer
   p_filter_follows_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(ce_filt) |-> (ce_filt == $past(ce_sync)));
endmodule

bind bus_cycle_sampler bcs_checker #(.ADDR_W(ADDR_W)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .dq_oe    (dq_oe),
   .wr_strobe(wr_strobe),
   .wr_addr  (wr_addr),
   .ce_filt  (ce_filt),
   .ce_sync  (ce_sync),
   .wr_act   (wr_act)
);

// File: tb/bus_cycle_sampler_tb.sv
module bus_cycle_sampler_tb;
   localparam int CLK_PERIOD = 10;
   localparam int AW = 8;
   localparam int DW = 8;
   localparam int GC = 3;
   localparam int GAP = 12;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          ce_n = 1'b1;
   logic          we_n = 1'b1;
   logic          oe_n = 1'b1;
   logic [AW-1:0] addr_in = '0;
   logic [DW-1:0] data_in = '0;
   logic          wr_strobe;
   logic [AW-1:0] wr_addr;
   logic [DW-1:0] wr_data;
   logic          rd_start;
   logic          dq_oe;

   int n_chk = 0;
   int n_bad = 0;
   int n_wr  = 0;
   int n_rd  = 0;
   logic [AW-1:0] last_a = '0;
   logic [DW-1:0] last_d = '0;
   bit done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   bus_cycle_sampler #(.ADDR_W(AW), .DATA_W(DW), .SYNC_STAGES(2), .GLITCH_CYC(GC)) u_dut (
      .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n),
      .addr_in(addr_in), .data_in(data_in), .wr_strobe(wr_strobe),
      .wr_addr(wr_addr), .wr_data(wr_data), .rd_start(rd_start), .dq_oe(dq_oe)
   );

   always @(negedge clk) begin
      if (wr_strobe) begin
         n_wr   = n_wr + 1;
         last_a = wr_addr;
         last_d = wr_data;
      end
      if (rd_start) n_rd = n_rd + 1;
   end

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic chk(input string req, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic summary();
      if (!done) begin
         done = 1'b1;
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      summary();
   end

   initial begin
      int w0;
      int r0;
      // R1: quiet while in reset, even with the pins asserted
      tick(8);
      chk("R1 strobe", wr_strobe, 0);
      chk("R1 rd_start", rd_start, 0);
      chk("R1 dq_oe", dq_oe, 0);
      chk("R1 wr_addr", wr_addr, 0);
      chk("R1 wr_data", wr_data, 0);
      ce_n = 0; oe_n = 0; tick(GAP);
      chk("R1 dq_oe pins low", dq_oe, 0);
      ce_n = 1; oe_n = 1; tick(GAP);
      rst_n = 1; tick(GAP);

      // R2/R3/R4: all four edge orderings, bus moved between the framing edges
      for (int i = 0; i < 8; i++) begin
         logic [AW-1:0] a;
         logic [DW-1:0] d;
         bit ce_first_fall;
         bit ce_first_rise;
         a = AW'(i * 37 + 5);
         d = DW'((i * 91 + 3) ^ 8'hA5);
         ce_first_fall = (i % 2) == 0;
         ce_first_rise = ((i / 2) % 2) == 0;
         w0 = n_wr;
         addr_in = ~a; data_in = d;
         if (ce_first_fall) ce_n = 0; else we_n = 0;
         tick(GAP);
         addr_in = a;
         tick(GAP);
         if (ce_first_fall) we_n = 0; else ce_n = 0;
         tick(GAP);
         addr_in = a ^ 8'h0F;
         tick(GAP);
         if (ce_first_rise) ce_n = 1; else we_n = 1;
         tick(GAP);
         data_in = ~d;
         tick(GAP);
         if (ce_first_rise) we_n = 1; else ce_n = 1;
         tick(GAP + 2);
         chk("R2 one strobe per cycle", n_wr - w0, 1);
         chk("R3 address at later fall", last_a, a);
         chk("R4 data at earlier rise", last_d, d);
      end

      // R8: low pulse width sweep on select with write strobe held low
      for (int len = 1; len <= GC + 2; len++) begin
         w0 = n_wr; r0 = n_rd;
         addr_in = AW'(len); data_in = DW'(len * 3);
         we_n = 0; tick(GAP);
         ce_n = 0; tick(len);
         ce_n = 1; tick(GAP + 2);
         we_n = 1; tick(GAP);
         chk("R8 select pulse write count", n_wr - w0, (len >= GC) ? 1 : 0);
         chk("R8 select pulse read count", n_rd - r0, (len >= GC) ? 1 : 0);
         if (len >= GC) chk("R8 accepted pulse address", last_a, len);
      end

      // R8: high pulse on write strobe inside a cycle, short then long
      for (int len = GC - 1; len <= GC; len++) begin
         w0 = n_wr;
         ce_n = 0; we_n = 0; tick(GAP);
         we_n = 1; tick(len);
         we_n = 0; tick(GAP);
         we_n = 1; ce_n = 1; tick(GAP + 2);
         chk("R8 write strobe high pulse", n_wr - w0, (len >= GC) ? 2 : 1);
      end

      // R5: read strobe low during the whole cycle, then only in the middle
      w0 = n_wr;
      oe_n = 0; tick(GAP);
      ce_n = 0; we_n = 0; tick(GAP);
      we_n = 1; ce_n = 1; tick(GAP);
      oe_n = 1; tick(GAP);
      chk("R5 read strobe low whole cycle", n_wr - w0, 0);
      w0 = n_wr;
      ce_n = 0; we_n = 0; tick(GAP);
      oe_n = 0; tick(8);
      oe_n = 1; tick(GAP);
      we_n = 1; ce_n = 1; tick(GAP + 2);
      chk("R5 read strobe low mid cycle", n_wr - w0, 0);

      // R9: output driver enable
      ce_n = 0; oe_n = 0; tick(GAP);
      chk("R9 both low", dq_oe, 1);
      oe_n = 1; tick(GAP);
      chk("R9 read strobe high", dq_oe, 0);
      ce_n = 1; oe_n = 0; tick(GAP);
      chk("R9 select high", dq_oe, 0);
      oe_n = 1; tick(GAP);

      // R6/R7: read starts
      r0 = n_rd;
      ce_n = 0; tick(GAP);
      chk("R6 select fall", n_rd - r0, 1);
      for (int k = 1; k <= 3; k++) begin
         addr_in = AW'(k * 29 + 1); tick(GAP);
      end
      chk("R7 address moves under select", n_rd - r0, 4);
      tick(GAP);
      chk("R7 steady address", n_rd - r0, 4);
      ce_n = 1; tick(GAP);
      r0 = n_rd;
      addr_in = 8'h5A; tick(GAP);
      chk("R7 address moves without select", n_rd - r0, 0);

      // R10: reset in the middle of a write
      w0 = n_wr;
      addr_in = 8'h3C; data_in = 8'hC3;
      ce_n = 0; we_n = 0; tick(GAP);
      rst_n = 0; tick(4);
      chk("R1 dq_oe in reset", dq_oe, 0);
      rst_n = 1; tick(GAP);
      we_n = 1; ce_n = 1; tick(GAP + 2);
      chk("R10 cancelled cycle", n_wr - w0, 0);
      addr_in = 8'h77; data_in = 8'h19;
      ce_n = 0; we_n = 0; tick(GAP);
      we_n = 1; ce_n = 1; tick(GAP + 2);
      chk("R10 next cycle accepted", n_wr - w0, 1);
      chk("R10 next cycle address", last_a, 8'h77);
      chk("R10 next cycle data", last_d, 8'h19);

      summary();
   end
endmodule